// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small eight-bit CPU core. The core's datapath reports events to it: a value written into an accumulator or index register, an add or subtract result with its operands, a bit-test operand, a single-flag set or clear command, or a whole status byte popped from the stack. The block updates the negative, overflow, decimal, interrupt-mask, zero and carry flags from these events. It also drives the byte that the core writes to the stack when it saves status, and that byte tells a software break apart from a hardware interrupt.

An active-low set-overflow pin can force the overflow flag high at any time. The pin is asynchronous to the core clock, so the block synchronises it and acts once on each falling edge. The core then only has to poll the flag to see that an I/O event has happened.

Top module: `status_flag_reg`

## Requirements
- R1: The status read-out `flags_o` places N at bit 7, V at bit 6, a constant 1 at bit 5, a constant 0 at bit 4, and D, I, Z, C at bits 3, 2, 1, 0. After reset it reads 8'h24 (only I set, with the constant 1).
- R2: A register load (`ld_en`) sets N to bit 7 of `ld_val` and sets Z when `ld_val` is zero. V, D, I and C keep their values.
- R3: An add/subtract (`arith_en`) sets N from bit 7 of `arith_res`, Z when `arith_res` is zero, and C from `arith_cout`. V is set when the two addends have the same sign and the result's sign differs from it, and is cleared otherwise. For subtraction (`arith_sub`=1) the second addend is `~arith_b`. D and I keep their values.
- R4: A bit test (`bit_en`) copies `bit_mem` bit 7 into N and bit 6 into V, and sets Z when `bit_mem & bit_acc` is zero. D, I and C keep their values.
- R5: `flag_cmd` encodes 0 = no change, 1 = clear C, 2 = set C, 3 = clear I, 4 = set I, 5 = clear D, 6 = set D, 7 = clear V. No code sets V.
- R6: A status pull (`pull_en`) loads N, V, D, I, Z, C from bits 7, 6, 3, 2, 1, 0 of `pull_val`. Bits 5 and 4 of the pulled byte have no effect.
- R7: A falling edge on `so_n` sets V. With SYNC_STAGES=2, V reads 1 after the third rising clock edge that follows the fall. Holding `so_n` low does not set V again, and a rising edge of `so_n` has no effect.
- R8: In the cycle where the set-overflow event takes effect, V becomes 1 whatever other operation in that cycle would have written to V, including clear-V and a pull.
- R9: When several operations are requested in one cycle, only the highest applies, in the order pull, add/subtract, bit test, register load, flag command.
- R10: `push_byte_o` equals the current N, V, D, I, Z, C in the R1 positions, with bit 5 = 1 and bit 4 = `brk_push`.
- R11: With no operation requested and no set-overflow event, all flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Register load event |
| ld_val | input | 8 | Value being loaded |
| arith_en | input | 1 | Add/subtract event |
| arith_sub | input | 1 | 1 = subtract (second operand inverted) |
| arith_a | input | 8 | First operand |
| arith_b | input | 8 | Second operand, before inversion |
| arith_res | input | 8 | ALU result |
| arith_cout | input | 1 | ALU carry out |
| bit_en | input | 1 | Bit-test event |
| bit_mem | input | 8 | Memory operand of the bit test |
| bit_acc | input | 8 | Accumulator value for the bit test |
| flag_cmd | input | 3 | Single-flag command code (R5) |
| pull_en | input | 1 | Status pull event |
| pull_val | input | 8 | Byte popped from the stack |
| so_n | input | 1 | Asynchronous active-low set-overflow pin |
| brk_push | input | 1 | 1 = software break push, 0 = hardware interrupt push |
| flags_o | output | 8 | Current status word |
| push_byte_o | output | 8 | Status byte for stack pushes |

## Verification
On every cycle the assertions check the push image against the status word, the N/Z/V results of loads, bit tests and pulls when they win priority, the dominance of the overflow event over a clear, and the holding of flags when idle. The signed-overflow results for specific operand pairs, the exact latency of the set-overflow pin, the absence of retriggering while the pin stays low, and priority among mixed simultaneous requests can only be shown by the bench's scenarios.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;

  localparam int SF_DW  = 8;
  localparam int SF_MSB = SF_DW - 1;

  typedef enum logic [2:0] {
    FCMD_NONE  = 3'd0,
    FCMD_CLR_C = 3'd1,
    FCMD_SET_C = 3'd2,
    FCMD_CLR_I = 3'd3,
    FCMD_SET_I = 3'd4,
    FCMD_CLR_D = 3'd5,
    FCMD_SET_D = 3'd6,
    FCMD_CLR_V = 3'd7
  } flag_cmd_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  function automatic logic is_zero(input logic [SF_MSB:0] val);
    return (val == '0);
  endfunction

  // Sign overflow: addends agree in sign, result disagrees.
  function automatic logic signed_ovf(input logic [SF_MSB:0] a,
                                      input logic [SF_MSB:0] b,
                                      input logic            sub,
                                      input logic [SF_MSB:0] r);
    logic [SF_MSB:0] b_eff;
    b_eff = sub ? ~b : b;
    return (a[SF_MSB] == b_eff[SF_MSB]) && (r[SF_MSB] != a[SF_MSB]);
  endfunction

  function automatic logic [SF_MSB:0] status_image(input flags_t f,
                                                   input logic   b_bit);
    return {f.n, f.v, 1'b1, b_bit, f.d, f.i, f.z, f.c};
  endfunction

endpackage

// File: rtl/sov_edge_sync.sv
module sov_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= pin_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[LAST];
  end

  assign fall_o = last_q & ~chain[LAST];
endmodule

// File: rtl/flag_next.sv
module flag_next
  import status_flag_pkg::*;
(
  input  flags_t          cur,
  input  logic            ld_en,
  input  logic [SF_MSB:0] ld_val,
  input  logic            arith_en,
  input  logic            arith_sub,
  input  logic [SF_MSB:0] arith_a,
  input  logic [SF_MSB:0] arith_b,
  input  logic [SF_MSB:0] arith_res,
  input  logic            arith_cout,
  input  logic            bit_en,
  input  logic [SF_MSB:0] bit_mem,
  input  logic [SF_MSB:0] bit_acc,
  input  flag_cmd_e       cmd,
  input  logic            pull_en,
  input  logic [SF_MSB:0] pull_val,
  input  logic            so_fall,
  output flags_t          nxt,
  output logic            sel_pull,
  output logic            sel_arith,
  output logic            sel_bit,
  output logic            sel_ld,
  output logic            sel_cmd
);
  always_comb begin
    sel_pull  = pull_en;
    sel_arith = arith_en & ~pull_en;
    sel_bit   = bit_en & ~pull_en & ~arith_en;
    sel_ld    = ld_en & ~pull_en & ~arith_en & ~bit_en;
    sel_cmd   = ~pull_en & ~arith_en & ~bit_en & ~ld_en;
  end

  always_comb begin
    nxt = cur;
    if (sel_pull) begin
      nxt.n = pull_val[7];
      nxt.v = pull_val[6];
      nxt.d = pull_val[3];
      nxt.i = pull_val[2];
      nxt.z = pull_val[1];
      nxt.c = pull_val[0];
    end else if (sel_arith) begin
      nxt.n = arith_res[SF_MSB];
      nxt.z = is_zero(arith_res);
      nxt.c = arith_cout;
      nxt.v = signed_ovf(arith_a, arith_b, arith_sub, arith_res);
    end else if (sel_bit) begin
      nxt.n = bit_mem[SF_MSB];
      nxt.v = bit_mem[SF_MSB-1];
      nxt.z = is_zero(bit_mem & bit_acc);
    end else if (sel_ld) begin
      nxt.n = ld_val[SF_MSB];
      nxt.z = is_zero(ld_val);
    end else begin
      unique case (cmd)
        FCMD_CLR_C: nxt.c = 1'b0;
        FCMD_SET_C: nxt.c = 1'b1;
        FCMD_CLR_I: nxt.i = 1'b0;
        FCMD_SET_I: nxt.i = 1'b1;
        FCMD_CLR_D: nxt.d = 1'b0;
        FCMD_SET_D: nxt.d = 1'b1;
        FCMD_CLR_V: nxt.v = 1'b0;
        default:    nxt = cur;
      endcase
    end
    if (so_fall) nxt.v = 1'b1;
  end
endmodule

// File: rtl/push_image.sv
module push_image
  import status_flag_pkg::*;
(
  input  flags_t          flags,
  input  logic            brk_push,
  output logic [SF_MSB:0] status_o,
  output logic [SF_MSB:0] push_o
);
  assign status_o = status_image(flags, 1'b0);
  assign push_o   = status_image(flags, brk_push);
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_flag_pkg::*;
#(
  parameter int   SYNC_STAGES    = 2,
  parameter logic RESET_IRQ_MASK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_en,
  input  logic [7:0] ld_val,
  input  logic       arith_en,
  input  logic       arith_sub,
  input  logic [7:0] arith_a,
  input  logic [7:0] arith_b,
  input  logic [7:0] arith_res,
  input  logic       arith_cout,
  input  logic       bit_en,
  input  logic [7:0] bit_mem,
  input  logic [7:0] bit_acc,
  input  logic [2:0] flag_cmd,
  input  logic       pull_en,
  input  logic [7:0] pull_val,
  input  logic       so_n,
  input  logic       brk_push,
  output logic [7:0] flags_o,
  output logic [7:0] push_byte_o
);
  localparam flags_t RESET_FLAGS = '{n: 1'b0, v: 1'b0, d: 1'b0,
                                     i: RESET_IRQ_MASK, z: 1'b0, c: 1'b0};

  flags_t flags_q;
  flags_t flags_d;
  logic   so_fall;
  logic   sel_pull, sel_arith, sel_bit, sel_ld, sel_cmd;

  sov_edge_sync #(.STAGES(SYNC_STAGES)) u_sov (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (so_n),
    .fall_o (so_fall)
  );

  flag_next u_next (
    .cur        (flags_q),
    .ld_en      (ld_en),
    .ld_val     (ld_val),
    .arith_en   (arith_en),
    .arith_sub  (arith_sub),
    .arith_a    (arith_a),
    .arith_b    (arith_b),
    .arith_res  (arith_res),
    .arith_cout (arith_cout),
    .bit_en     (bit_en),
    .bit_mem    (bit_mem),
    .bit_acc    (bit_acc),
    .cmd        (flag_cmd_e'(flag_cmd)),
    .pull_en    (pull_en),
    .pull_val   (pull_val),
    .so_fall    (so_fall),
    .nxt        (flags_d),
    .sel_pull   (sel_pull),
    .sel_arith  (sel_arith),
    .sel_bit    (sel_bit),
    .sel_ld     (sel_ld),
    .sel_cmd    (sel_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= RESET_FLAGS;
    else        flags_q <= flags_d;
  end

  push_image u_img (
    .flags    (flags_q),
    .brk_push (brk_push),
    .status_o (flags_o),
    .push_o   (push_byte_o)
  );
endmodule

// File: rtl/status_flag_chk.sv
module status_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_en,
  input logic [7:0] ld_val,
  input logic       bit_en,
  input logic [7:0] bit_mem,
  input logic [2:0] flag_cmd,
  input logic       pull_en,
  input logic [7:0] pull_val,
  input logic       brk_push,
  input logic [7:0] flags_o,
  input logic [7:0] push_byte_o,
  input logic       so_fall,
  input logic       sel_arith,
  input logic       sel_bit,
  input logic       sel_ld,
  input logic       sel_cmd
);
  p_push_image_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_byte_o == {flags_o[7:5], brk_push, flags_o[3:0]});

  p_load_nz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && sel_ld) |=> (flags_o[7] == $past(ld_val[7])) &&
                          (flags_o[1] == ($past(ld_val) == 8'h00)));

  p_bit_nv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sel_bit && !so_fall) |=> flags_o[7:6] == $past(bit_mem[7:6]));

  p_pull_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en && !so_fall) |=> (flags_o[7:6] == $past(pull_val[7:6])) &&
                              (flags_o[3:0] == $past(pull_val[3:0])));

  p_sov_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    so_fall |=> flags_o[6]);

  p_clv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd && flag_cmd == 3'd7 && !so_fall) |=> !flags_o[6]);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd && flag_cmd == 3'd0 && !so_fall) |=> $stable(flags_o));

  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pull_en, sel_arith, sel_bit, sel_ld}));
endmodule

bind status_flag_reg status_flag_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_en       (ld_en),
  .ld_val      (ld_val),
  .bit_en      (bit_en),
  .bit_mem     (bit_mem),
  .flag_cmd    (flag_cmd),
  .pull_en     (pull_en),
  .pull_val    (pull_val),
  .brk_push    (brk_push),
  .flags_o     (flags_o),
  .push_byte_o (push_byte_o),
  .so_fall     (so_fall),
  .sel_arith   (sel_arith),
  .sel_bit     (sel_bit),
  .sel_ld      (sel_ld),
  .sel_cmd     (sel_cmd)
);

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en, arith_en, arith_sub, arith_cout, bit_en, pull_en, brk_push;
  logic       so_n = 1'b1;
  logic [7:0] ld_val, arith_a, arith_b, arith_res, bit_mem, bit_acc, pull_val;
  logic [2:0] flag_cmd;
  logic [7:0] flags_o, push_byte_o;

  status_flag_reg i_status_flag_reg (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] m;            // expected status word
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic clr_in();
    ld_en = 0; arith_en = 0; arith_sub = 0; arith_cout = 0; bit_en = 0;
    pull_en = 0; brk_push = 0; ld_val = 0; arith_a = 0; arith_b = 0;
    arith_res = 0; bit_mem = 0; bit_acc = 0; pull_val = 0; flag_cmd = 3'd0;
  endtask

  task automatic push_exp(string tag);
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic do_idle(string tag);
    @(negedge clk); clr_in(); push_exp(tag);
  endtask

  task automatic do_ld(logic [7:0] v);
    @(negedge clk); clr_in();
    ld_en = 1; ld_val = v;
    m[7] = v[7]; m[1] = (v == 8'h00);
    push_exp("R2");
  endtask

  // Expected V from signed integer range, not from sign-bit patterns
  task automatic do_arith(logic [7:0] a, logic [7:0] b, logic sub, logic cin, string tag);
    logic [7:0] bp;
    logic [8:0] sum;
    int sa, sb, t;
    @(negedge clk); clr_in();
    bp  = sub ? ~b : b;
    sum = {1'b0, a} + {1'b0, bp} + {8'h00, cin};
    sa  = (a  > 127) ? int'(a)  - 256 : int'(a);
    sb  = (bp > 127) ? int'(bp) - 256 : int'(bp);
    t   = sa + sb + int'(cin);
    arith_en = 1; arith_sub = sub; arith_a = a; arith_b = b;
    arith_res = sum[7:0]; arith_cout = sum[8];
    m[7] = sum[7]; m[1] = (sum[7:0] == 0); m[0] = sum[8];
    m[6] = (t > 127) || (t < -128);
    push_exp(tag);
  endtask

  task automatic do_bit(logic [7:0] mem, logic [7:0] acc);
    @(negedge clk); clr_in();
    bit_en = 1; bit_mem = mem; bit_acc = acc;
    m[7] = mem[7]; m[6] = mem[6]; m[1] = ((mem & acc) == 0);
    push_exp("R4");
  endtask

  task automatic do_cmd(logic [2:0] code, string tag);
    @(negedge clk); clr_in();
    flag_cmd = code;
    case (code)
      3'd1: m[0] = 0;  3'd2: m[0] = 1;
      3'd3: m[2] = 0;  3'd4: m[2] = 1;
      3'd5: m[3] = 0;  3'd6: m[3] = 1;
      3'd7: m[6] = 0;  default: ;
    endcase
    push_exp(tag);
  endtask

  task automatic do_pull(logic [7:0] v);
    @(negedge clk); clr_in();
    pull_en = 1; pull_val = v;
    m = {v[7:6], 2'b10, v[3:0]};
    push_exp("R6");
  endtask

  task automatic do_push_check(logic brk);
    @(negedge clk); clr_in();
    brk_push = brk;
    #1 check("R10", push_byte_o, {m[7:6], 1'b1, brk, m[3:0]});
    push_exp("R11");
  endtask

  // Monitor: compares the registered status after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), flags_o, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clr_in();
    m = 8'h24;
    repeat (3) @(negedge clk);
    check("R1", flags_o, 8'h24);
    rst_n = 1;
    do_idle("R11");
    check("R1", flags_o, 8'h24);

    do_ld(8'h00);                 // Z set, N clear
    do_ld(8'h9C);                 // N set, Z clear
    do_arith(8'h7B, 8'h2D, 0, 0, "R3");   // 123+45 overflow
    do_arith(8'h85, 8'hD3, 0, 0, "R3");   // -123 + -45 overflow
    do_arith(8'h50, 8'h10, 1, 1, "R3");   // 80-16 no overflow, carry
    do_arith(8'h7B, 8'hD3, 1, 1, "R3");   // 123-(-45) overflow
    do_arith(8'h10, 8'h10, 1, 1, "R3");   // zero result
    do_arith(8'h7F, 8'h00, 0, 1, "R3");   // overflow through carry in
    do_bit(8'hC0, 8'h0F);
    do_bit(8'h41, 8'h01);
    do_cmd(3'd2, "R5"); do_cmd(3'd6, "R5"); do_cmd(3'd3, "R5");
    do_cmd(3'd7, "R5"); do_cmd(3'd1, "R5"); do_cmd(3'd5, "R5");
    do_cmd(3'd4, "R5"); do_cmd(3'd0, "R5");
    do_pull(8'hFF);               // bits 5,4 ignored -> EF
    do_push_check(1'b1);
    do_push_check(1'b0);
    do_pull(8'h30);               // only ignored bits set -> 20
    do_push_check(1'b1);

    // R9: pull beats load and command
    @(negedge clk); clr_in();
    pull_en = 1; pull_val = 8'hC3; ld_en = 1; ld_val = 8'h00; flag_cmd = 3'd5;
    m = 8'hE3; push_exp("R9");
    // R9: add/subtract beats bit test and load
    @(negedge clk); clr_in();
    arith_en = 1; arith_a = 8'h01; arith_b = 8'h01; arith_res = 8'h02;
    bit_en = 1; bit_mem = 8'hC0; ld_en = 1; ld_val = 8'h80;
    m[7] = 0; m[6] = 0; m[1] = 0; m[0] = 0; push_exp("R9");
    // R9: bit test beats load
    @(negedge clk); clr_in();
    bit_en = 1; bit_mem = 8'h40; bit_acc = 8'h40; ld_en = 1; ld_val = 8'h00;
    m[7] = 0; m[6] = 1; m[1] = 0; push_exp("R9");
    do_cmd(3'd7, "R5");

    // R7/R8: set-overflow pin, effect lands three edges after the fall
    @(negedge clk); clr_in(); so_n = 0; push_exp("R7");
    do_idle("R7");
    @(negedge clk); clr_in(); flag_cmd = 3'd7; m[6] = 1; push_exp("R8");
    do_idle("R7");
    do_cmd(3'd7, "R7");           // held low: no retrigger
    do_idle("R7");
    @(negedge clk); clr_in(); so_n = 1; push_exp("R7");
    do_idle("R7"); do_idle("R7"); do_idle("R7");
    @(negedge clk); clr_in(); so_n = 0; push_exp("R7");
    do_idle("R7");
    @(negedge clk); clr_in(); pull_en = 1; pull_val = 8'h00;
    m = 8'h60; push_exp("R8");    // pull clears others, V still forced
    @(negedge clk); clr_in(); so_n = 1; push_exp("R11");
    do_idle("R11"); do_idle("R11");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule